// File: doc/BRIEF.md
# Multi-Bank Integer Clock Divider with Coincidence Sync

This block derives four divided clocks from one fast source clock: three output banks (A, B, C) and a feedback output (FB). Each ratio, odd or even, comes from small select codes plus a range select that doubles every ratio when low. All dividers share one time base. They are cleared together after reset and after any configuration change, so their rising edges line up on the first counted source edge. A one-cycle sync pulse marks every counted edge on which bank A and bank C rise together.

Bank B can run in anti-phase to the other banks. Each output has its own enable. A disabled output stops only at its next falling edge and restarts only at its next natural rising edge, so no shortened pulse ever appears on any output. In bypass mode the dividers stop counting source cycles. They count rising edges of a reference input instead, after that input has passed through a two-stage synchronizer. Every output and the sync pulse are driven straight from flops.

Top module: `clkdiv_banks`

## Requirements
- R1: While `rst_n` is low, all four clock outputs and `sync_out` are 0. On the first source edge after release, every enabled, non-inverted output goes high together.
- R2: The FB ratio for `sel_fb` codes 0 to 7 is 4, 6, 8, 10, 8, 12, 16, 20 when `vco_hi`=1, and twice those values when `vco_hi`=0. The FB ratio does not depend on the bank selects.
- R3: The bank ratios for codes 0 to 3 are as follows when `vco_hi`=1, and twice these values when `vco_hi`=0: A is 2, 3, 4, 5; B is 2, 4, 5, 6; C is 2, 4, 6, 8.
- R4: With ratio N, each output is high for floor(N/2) counted edges and then low for the remaining ceil(N/2) counted edges.
- R5: `sync_out` is high for exactly one source cycle, and only after a counted edge on which both the A and C dividers rise. Enables do not affect it. It repeats every LCM(NA, NC) counted edges.
- R6: With `inv_b`=1, bank B is the complement of its normal phase. It is low for the first floor(N/2) counted edges of each period and rises at counted edge floor(N/2).
- R7: When an output's enable bit (`out_en` bit 0=A, 1=B, 2=C, 3=FB) is cleared, a high phase already under way completes. The output then holds low from its next falling edge.
- R8: When an enable bit is set, the output stays low until that divider's next natural rising edge, and then runs normally.
- R9: With `bypass`=1, one edge is counted at the second source edge after `ref_in` is first sampled high following a low. No other source edge advances the dividers.
- R10: Any change of `bypass`, `vco_hi`, `inv_b` or a select restarts all dividers. At the next edge all outputs go low, and on the counted edge after that the outputs restart aligned, as after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Fast source clock for all logic |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | 1 | Reference clock, counted in bypass mode |
| bypass | input | 1 | 1: count reference edges instead of source cycles |
| vco_hi | input | 1 | Range select; 0 doubles every ratio |
| inv_b | input | 1 | 1: bank B in anti-phase |
| sel_a | input | 2 | Bank A ratio code |
| sel_b | input | 2 | Bank B ratio code |
| sel_c | input | 2 | Bank C ratio code |
| sel_fb | input | 3 | Feedback ratio code |
| out_en | input | 4 | Per-output enable (A, B, C, FB from bit 0) |
| clk_a | output | 1 | Bank A clock |
| clk_b | output | 1 | Bank B clock |
| clk_c | output | 1 | Bank C clock |
| clk_fb | output | 1 | Feedback clock |
| sync_out | output | 1 | A/C rising-edge coincidence pulse |

## Verification
Every output and `sync_out` is a flop that reflects a counted edge at that same source edge. The bench therefore updates its model just after each rising edge and compares on the following falling edge, with no added latency. A configuration change yields all-low outputs one edge later, and the restarted pattern begins on the next counted edge. In bypass mode a counted edge lands two source edges after `ref_in` is driven high, and the bench model delays its view of the reference by those two stages. Directed sequences check enable changes on exact counted-edge indices, measure the FB period for all sixteen codes and measure sync gaps. Constrained-random configurations cover the rest.

// File: rtl/clkdiv_pkg.sv
// Shared constants and ratio tables for the multi-bank clock divider.
// Assumes every ratio is at least 2 and fits in CNT_W bits.
package clkdiv_pkg;
    localparam int CNT_W   = 6;
    localparam int NUM_OUT = 4;
    localparam int IDX_A   = 0;
    localparam int IDX_B   = 1;
    localparam int IDX_C   = 2;
    localparam int IDX_FB  = 3;

    // Live configuration; any change of it restarts every divider.
    typedef struct packed {
        logic       bypass;
        logic       vco_hi;
        logic       inv_b;
        logic [2:0] sel_fb;
        logic [1:0] sel_c;
        logic [1:0] sel_b;
        logic [1:0] sel_a;
    } cfg_t;

    // Scale a high-range ratio down to the low range (doubling).
    function automatic int scale_range(int base, logic hi);
        return hi ? base : 2 * base;
    endfunction

    // Bank A: 2,3,4,5 in the high range.
    function automatic int div_a(logic [1:0] s, logic hi);
        return scale_range(int'(s) + 2, hi);
    endfunction

    // Bank B: 2,4,5,6 in the high range.
    function automatic int div_b(logic [1:0] s, logic hi);
        return scale_range((s == 2'd0) ? 2 : int'(s) + 3, hi);
    endfunction

    // Bank C: 2,4,6,8 in the high range.
    function automatic int div_c(logic [1:0] s, logic hi);
        return scale_range(2 * (int'(s) + 1), hi);
    endfunction

    // Feedback: (4 + 2*low bits), doubled by the top code bit.
    function automatic int div_fb(logic [2:0] s, logic hi);
        int base;
        base = 4 + 2 * int'(s[1:0]);
        if (s[2]) base = 2 * base;
        return scale_range(base, hi);
    endfunction
endpackage

// File: rtl/clkdiv_ratio_decode.sv
// Turns the select codes into one divide ratio per output.
// Pure combinational; assumes the tables in clkdiv_pkg give ratios >= 2.
module clkdiv_ratio_decode #(
    parameter int W = clkdiv_pkg::CNT_W,
    parameter int N = clkdiv_pkg::NUM_OUT
) (
    input  logic              vco_hi,
    input  logic [1:0]        sel_a,
    input  logic [1:0]        sel_b,
    input  logic [1:0]        sel_c,
    input  logic [2:0]        sel_fb,
    output logic [N-1:0][W-1:0] ratio
);
    import clkdiv_pkg::*;

    // Look up each output's ratio from its own select code.
    always_comb begin
        ratio          = '0;
        ratio[IDX_A]   = W'(div_a(sel_a, vco_hi));
        ratio[IDX_B]   = W'(div_b(sel_b, vco_hi));
        ratio[IDX_C]   = W'(div_c(sel_c, vco_hi));
        ratio[IDX_FB]  = W'(div_fb(sel_fb, vco_hi));
    end
endmodule

// File: rtl/clkdiv_tick.sv
// Produces the divider advance strobe. Outside bypass it is high on every
// source cycle. In bypass it is high for one cycle per synchronized rising
// edge of the reference input. Assumes ref_in is slower than half of clk.
module clkdiv_tick #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bypass,
    input  logic ref_in,
    output logic tick
);
    logic [STAGES-1:0] ref_sh;
    logic              ref_rise;

    // Shift the reference through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) ref_sh <= '0;
        else        ref_sh <= {ref_sh[STAGES-2:0], ref_in};
    end

    // Rising edge seen between the last two stages.
    always_comb ref_rise = ref_sh[STAGES-2] & ~ref_sh[STAGES-1];

    // Select the advance strobe for the current mode.
    always_comb tick = bypass ? ref_rise : 1'b1;

    // R9
    ref_rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_rise |=> !ref_rise);
endmodule

// File: rtl/clkdiv_counter.sv
// Modulo-N counter for one output. It reports the next output phase and
// whether the next counted edge is a natural rising or falling edge.
// Phase is high for counts 0..N/2-1 (inverted when invert=1). Reset and
// restart load N-1, so the next counted edge is count 0.
module clkdiv_counter #(
    parameter int W = clkdiv_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         restart,
    input  logic         invert,
    input  logic [W-1:0] ratio,
    output logic         ph_nxt,
    output logic         rise_nxt,
    output logic         fall_nxt
);
    logic [W-1:0] cnt, cnt_adv, cnt_n, half, last;

    // Work out the next count and the edge events it implies.
    always_comb begin
        last     = ratio - 1'b1;
        half     = ratio >> 1;
        cnt_adv  = (cnt >= last) ? W'(0) : cnt + 1'b1;
        cnt_n    = restart ? last : (tick ? cnt_adv : cnt);
        ph_nxt   = invert ? (cnt_n >= half) : (cnt_n < half);
        rise_nxt = tick && !restart && (cnt_adv == (invert ? half : W'(0)));
        fall_nxt = tick && !restart && (cnt_adv == (invert ? W'(0) : half));
    end

    // Hold the count; reset parks it just before count 0.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= last;
        else        cnt <= cnt_n;
    end

    // R4
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |-> (cnt < ratio));
endmodule

// File: rtl/clkdiv_gate.sv
// Clean stop-low gate for one output. The run flag drops only on a natural
// falling edge and rises only on a natural rising edge, so every pulse has
// full width. The output is a flop equal to run AND phase.
module clkdiv_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic enable,
    input  logic ph_nxt,
    input  logic rise_nxt,
    input  logic fall_nxt,
    output logic q
);
    logic run, run_n;

    // Decide whether the output runs after this edge.
    always_comb begin
        run_n = run;
        if (restart)                         run_n = 1'b0;
        else if (!run && enable && rise_nxt) run_n = 1'b1;
        else if (run && !enable && fall_nxt) run_n = 1'b0;
    end

    // Register the run flag and the gated output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            q   <= 1'b0;
        end else begin
            run <= run_n;
            q   <= run_n & ph_nxt;
        end
    end

    // R8
    rise_natural_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q) |-> $past(rise_nxt));

    // R7
    fall_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q) |-> ($past(fall_nxt) || $past(restart) || $past(!rst_n)));
endmodule

// File: rtl/clkdiv_banks.sv
// Top of the multi-bank divider: three banks plus feedback, all counted
// from one strobe. There is a registered A/C coincidence pulse and
// per-output clean stop-low gating. A configuration change restarts all
// dividers at once. Assumes inputs are synchronous to clk_src, apart from
// ref_in.
module clkdiv_banks #(
    parameter int CNT_W      = clkdiv_pkg::CNT_W,
    parameter int REF_STAGES = 2,
    parameter int INV_BANK   = clkdiv_pkg::IDX_B
) (
    input  logic                          clk_src,
    input  logic                          rst_n,
    input  logic                          ref_in,
    input  logic                          bypass,
    input  logic                          vco_hi,
    input  logic                          inv_b,
    input  logic [1:0]                    sel_a,
    input  logic [1:0]                    sel_b,
    input  logic [1:0]                    sel_c,
    input  logic [2:0]                    sel_fb,
    input  logic [clkdiv_pkg::NUM_OUT-1:0] out_en,
    output logic                          clk_a,
    output logic                          clk_b,
    output logic                          clk_c,
    output logic                          clk_fb,
    output logic                          sync_out
);
    import clkdiv_pkg::*;

    localparam int NO = NUM_OUT;

    cfg_t                 cfg_live, cfg_q;
    logic                 restart, tick;
    logic [NO-1:0][CNT_W-1:0] ratio;
    logic [NO-1:0]        ph_nxt, rise_nxt, fall_nxt, q_out;
    logic                 sync_q;

    // Gather the live configuration into one word.
    always_comb cfg_live = '{bypass: bypass, vco_hi: vco_hi, inv_b: inv_b,
                             sel_fb: sel_fb, sel_c: sel_c, sel_b: sel_b,
                             sel_a: sel_a};

    // Track the previous configuration (also loaded during reset).
    always_ff @(posedge clk_src) cfg_q <= cfg_live;

    // Any configuration change restarts every divider together.
    always_comb restart = (cfg_live != cfg_q);

    clkdiv_ratio_decode #(.W(CNT_W), .N(NO)) u_dec (
        .vco_hi (vco_hi),
        .sel_a  (sel_a),
        .sel_b  (sel_b),
        .sel_c  (sel_c),
        .sel_fb (sel_fb),
        .ratio  (ratio)
    );

    clkdiv_tick #(.STAGES(REF_STAGES)) u_tick (
        .clk    (clk_src),
        .rst_n  (rst_n),
        .bypass (bypass),
        .ref_in (ref_in),
        .tick   (tick)
    );

    for (genvar i = 0; i < NO; i++) begin : g_out
        localparam bit CAN_INV = (i == INV_BANK);

        clkdiv_counter #(.W(CNT_W)) u_cnt (
            .clk      (clk_src),
            .rst_n    (rst_n),
            .tick     (tick),
            .restart  (restart),
            .invert   (CAN_INV & inv_b),
            .ratio    (ratio[i]),
            .ph_nxt   (ph_nxt[i]),
            .rise_nxt (rise_nxt[i]),
            .fall_nxt (fall_nxt[i])
        );

        clkdiv_gate u_gate (
            .clk      (clk_src),
            .rst_n    (rst_n),
            .restart  (restart),
            .enable   (out_en[i]),
            .ph_nxt   (ph_nxt[i]),
            .rise_nxt (rise_nxt[i]),
            .fall_nxt (fall_nxt[i]),
            .q        (q_out[i])
        );
    end

    // Register the A/C rising-edge coincidence, independent of the enables.
    always_ff @(posedge clk_src) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= rise_nxt[IDX_A] & rise_nxt[IDX_C];
    end

    // Drive the ports from the gate flops.
    always_comb begin
        clk_a    = q_out[IDX_A];
        clk_b    = q_out[IDX_B];
        clk_c    = q_out[IDX_C];
        clk_fb   = q_out[IDX_FB];
        sync_out = sync_q;
    end

    // R5
    sync_one_cycle_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
        sync_q |=> !sync_q);

    // R10
    restart_low_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
        restart |=> (q_out == '0) && !sync_q);
endmodule

// File: tb/tb_clkdiv_banks.sv
module tb_clkdiv_banks;
    localparam int CYC = 8;

    logic clk = 1'b0;
    always #(CYC/2) clk = ~clk;

    logic       rst_n, ref_in, bypass, vco_hi, inv_b;
    logic [1:0] sel_a, sel_b, sel_c;
    logic [2:0] sel_fb;
    logic [3:0] out_en;
    logic       clk_a, clk_b, clk_c, clk_fb, sync_out;

    int n_cmp = 0;
    int n_bad = 0;

    // Bench model state
    logic [11:0] cfg_prev;
    int          k;
    bit          run_e [4];
    bit          q_e [4];
    bit          sync_e;
    bit          rp1, rp2;

    clkdiv_banks dut (
        .clk_src(clk), .rst_n(rst_n), .ref_in(ref_in), .bypass(bypass),
        .vco_hi(vco_hi), .inv_b(inv_b), .sel_a(sel_a), .sel_b(sel_b),
        .sel_c(sel_c), .sel_fb(sel_fb), .out_en(out_en),
        .clk_a(clk_a), .clk_b(clk_b), .clk_c(clk_c), .clk_fb(clk_fb),
        .sync_out(sync_out)
    );

    // Ratio tables written from R2 and R3.
    function automatic int exp_ratio(int idx);
        int b;
        case (idx)
            0: case (sel_a) 2'd0: b = 2; 2'd1: b = 3; 2'd2: b = 4; default: b = 5; endcase
            1: case (sel_b) 2'd0: b = 2; 2'd1: b = 4; 2'd2: b = 5; default: b = 6; endcase
            2: case (sel_c) 2'd0: b = 2; 2'd1: b = 4; 2'd2: b = 6; default: b = 8; endcase
            default: case (sel_fb)
                3'd0: b = 4;  3'd1: b = 6;  3'd2: b = 8;  3'd3: b = 10;
                3'd4: b = 8;  3'd5: b = 12; 3'd6: b = 16; default: b = 20;
            endcase
        endcase
        return vco_hi ? b : 2 * b;
    endfunction

    function automatic int gcd(int a, int b);
        while (b != 0) begin
            int t;
            t = a % b; a = b; b = t;
        end
        return a;
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Advance the model by one source edge using the inputs held at that edge.
    task automatic model_update();
        logic [11:0] cfg_now;
        bit rs, tk, inv, rise, fall, ph;
        int n, h, r;
        cfg_now = {bypass, vco_hi, inv_b, sel_fb, sel_c, sel_b, sel_a};
        if (!rst_n) begin
            cfg_prev = cfg_now; k = -1; sync_e = 0; rp1 = 0; rp2 = 0;
            for (int i = 0; i < 4; i++) begin run_e[i] = 0; q_e[i] = 0; end
        end else begin
            rs = (cfg_now != cfg_prev);
            tk = bypass ? (rp1 && !rp2) : 1'b1;
            cfg_prev = cfg_now; rp2 = rp1; rp1 = ref_in;
            if (rs) begin
                k = -1; sync_e = 0;
                for (int i = 0; i < 4; i++) begin run_e[i] = 0; q_e[i] = 0; end
            end else if (tk) begin
                k++;
                for (int i = 0; i < 4; i++) begin
                    n = exp_ratio(i); h = n / 2; r = k % n;
                    inv  = (i == 1) && inv_b;
                    rise = inv ? (r == h) : (r == 0);
                    fall = inv ? (r == 0) : (r == h);
                    if (!run_e[i] && out_en[i] && rise) run_e[i] = 1;
                    else if (run_e[i] && !out_en[i] && fall) run_e[i] = 0;
                    ph = inv ? (r >= h) : (r < h);
                    q_e[i] = run_e[i] && ph;
                end
                sync_e = ((k % exp_ratio(0)) == 0) && ((k % exp_ratio(2)) == 0);
            end else begin
                sync_e = 0;
            end
        end
    endtask

    task automatic compare_all();
        string rb;
        rb = bypass ? "R9" : (inv_b ? "R6" : "R3");
        check(bypass ? "R9" : "R3", "clk_a", clk_a, q_e[0]);
        check(rb, "clk_b", clk_b, q_e[1]);
        check(bypass ? "R9" : "R3", "clk_c", clk_c, q_e[2]);
        check(bypass ? "R9" : "R2", "clk_fb", clk_fb, q_e[3]);
        check("R5", "sync_out", sync_out, sync_e);
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare_all();
    endtask

    task automatic set_cfg(bit byp, bit vh, bit ib, int a, int b, int c, int f);
        bypass = byp; vco_hi = vh; inv_b = ib;
        sel_a = 2'(a); sel_b = 2'(b); sel_c = 2'(c); sel_fb = 3'(f);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CYC * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int first, second, hi_cnt, last_s, na, nc, lcm;
        logic pa;
        void'($urandom(32'd20240611));
        rst_n = 0; ref_in = 0; out_en = 4'hF;
        set_cfg(0, 1, 0, 2, 1, 2, 0);
        @(negedge clk);

        // R1: reset state
        for (int i = 0; i < 3; i++) step();
        check("R1", "all low in reset", {clk_a, clk_b, clk_c, clk_fb, sync_out}, 0);
        rst_n = 1;
        step();
        check("R1", "aligned first rise", {clk_a, clk_b, clk_c, clk_fb}, 4'hF);
        for (int i = 0; i < 40; i++) step();

        // R10: config change restarts all dividers
        sel_c = 2'd3;
        step();
        check("R10", "all low after change", {clk_a, clk_b, clk_c, clk_fb, sync_out}, 0);
        step();
        check("R10", "realigned rise", {clk_a, clk_c, clk_fb}, 3'b111);

        // R2: feedback period for every code in both ranges
        for (int vh = 0; vh < 2; vh++) begin
            for (int f = 0; f < 8; f++) begin
                set_cfg(0, vh[0], 0, 1, 1, 1, f);
                step();
                first = -1; second = -1; pa = 0;
                for (int t = 0; t < 90 && second < 0; t++) begin
                    step();
                    if (clk_fb && !pa) begin
                        if (first < 0) first = t; else second = t;
                    end
                    pa = clk_fb;
                end
                check("R2", "feedback period", second - first, exp_ratio(3));
            end
        end

        // R4: odd ratios 3 and 5 on bank A, high floor(N/2) per period
        set_cfg(0, 1, 0, 1, 0, 0, 0);
        step(); hi_cnt = 0;
        for (int t = 0; t < 30; t++) begin step(); hi_cnt += clk_a; end
        check("R4", "ratio 3 high count", hi_cnt, 10);
        set_cfg(0, 1, 0, 3, 0, 0, 0);
        step(); hi_cnt = 0;
        for (int t = 0; t < 60; t++) begin step(); hi_cnt += clk_a; end
        check("R4", "ratio 5 high count", hi_cnt, 24);

        // R5: sync gaps equal LCM and pulses are one cycle wide
        for (int p = 0; p < 3; p++) begin
            case (p)
                0: set_cfg(0, 1, 0, 2, 0, 2, 0);   // 4 and 6
                1: set_cfg(0, 1, 0, 3, 0, 3, 0);   // 5 and 8
                default: set_cfg(0, 1, 0, 1, 0, 0, 0); // 3 and 2
            endcase
            na = exp_ratio(0); nc = exp_ratio(2); lcm = na * nc / gcd(na, nc);
            step(); last_s = -1; pa = 0;
            for (int t = 0; t < 3 * lcm + 1; t++) begin
                step();
                if (sync_out) begin
                    if (pa) check("R5", "sync width", 2, 1);
                    if (last_s >= 0) check("R5", "sync gap", t - last_s, lcm);
                    last_s = t;
                end
                pa = sync_out;
            end
        end

        // R6: inverted bank B of ratio 6 rises at counted edge 3
        set_cfg(0, 1, 1, 0, 3, 0, 0);
        step();
        step(); check("R6", "inv low at k0", clk_b, 0);
        step(); step();
        step(); check("R6", "inv high at k3", clk_b, 1);
        step(); step();
        step(); check("R6", "inv low at k6", clk_b, 0);

        // R7/R8: stop and restart on bank A with ratio 8
        set_cfg(0, 0, 0, 2, 0, 0, 0);
        step(); step(); step();        // k=1, high
        out_en[0] = 0;
        step(); check("R7", "high completes k2", clk_a, 1);
        step(); check("R7", "high completes k3", clk_a, 1);
        for (int t = 4; t <= 13; t++) begin
            step(); check("R7", "held low", clk_a, 0);
        end
        out_en[0] = 1;                 // k=13, r=5
        step(); check("R8", "no early restart r6", clk_a, 0);
        step(); check("R8", "no early restart r7", clk_a, 0);
        step(); check("R8", "restart at rise", clk_a, 1);

        // R9: bypass with a regular reference
        set_cfg(1, 1, 0, 1, 2, 3, 2);
        for (int t = 0; t < 240; t++) begin
            ref_in = ((t / 3) % 2) == 1;
            step();
        end

        // Constrained random configurations, enables and reference
        for (int c = 0; c < 25; c++) begin
            set_cfg(($urandom % 4) == 0, $urandom % 2, $urandom % 2,
                    $urandom % 4, $urandom % 4, $urandom % 4, $urandom % 8);
            for (int t = 0; t < 160; t++) begin
                if (($urandom % 12) == 0) out_en[$urandom % 4] ^= 1'b1;
                if (($urandom % 3) == 0) ref_in = ~ref_in;
                step();
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule